// File: doc/BRIEF.md
# Cascaded Clock-Unit Reset Sequencer

This block controls the resets of two clock-synthesis units that are chained. The downstream unit takes its input clock from an output of the upstream unit. Configuration can finish before the upstream unit produces a clean clock, so the block first keeps the upstream unit in reset for a programmable number of reference-clock cycles. It then releases that reset and watches the upstream lock.

The downstream unit stays in reset until the upstream unit has reported lock continuously for a fixed run of cycles. That run is timed by a shift chain that comes out of reset full of ones. A lock that appears early, before or just after configuration, therefore never frees the downstream stage at once. If either lock drops later, the block clears the combined status. A loss of upstream lock also pushes the downstream unit back into reset, and the block then runs the release sequence again.

A small counter records how many times the downstream reset was re-applied after the system first reached full lock. This helps when diagnosing lock losses. Both lock inputs are asynchronous and are synchronised into the reference-clock domain before use.

Top module: `cascade_rst_seq`

## Requirements
- R1: While `rst` is sampled high, and in the cycle after it is released, `up_rst` and `dn_rst` are 1 and `all_locked` and `relock_count` are 0.
- R2: `up_rst` is 1 whenever `cfg_done` was sampled low at the last edge. It falls after exactly HOLD_CYCLES consecutive edges with `cfg_done` sampled high. It rises again one cycle after `cfg_done` is sampled low.
- R3: Every assertion of `up_rst` lasts at least 3 reference cycles, because HOLD_CYCLES must be at least 3.
- R4: Each lock input passes through two flip-flops, so a change at a lock pin first affects the outputs through the synchronised value two edges later.
- R5: `dn_rst` is 1 one cycle after any edge where `up_rst` is 1 or the synchronised upstream lock is 0.
- R6: `dn_rst` falls only after STAGES (default 16) consecutive edges where `up_rst` is 0 and the synchronised upstream lock is 1. An upstream lock seen while `up_rst` is high does not shorten this.
- R7: After `rst`, the delay chain is all ones. This keeps `dn_rst` high for at least STAGES cycles even if the upstream lock is already high.
- R8: `all_locked` is a register loaded with (synchronised upstream lock AND synchronised downstream lock AND NOT `dn_rst`). It falls one edge after either synchronised lock falls.
- R9: `relock_count` increments by 1, modulo 2^CNT_W, at each 0-to-1 change of `dn_rst` that happens after `all_locked` has been 1 at least once since `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| cfg_done | input | 1 | Configuration complete flag |
| up_lock | input | 1 | Lock indication of the upstream clock unit (asynchronous) |
| dn_lock | input | 1 | Lock indication of the downstream clock unit (asynchronous) |
| up_rst | output | 1 | Active-high reset to the upstream clock unit |
| dn_rst | output | 1 | Active-high reset to the downstream clock unit |
| all_locked | output | 1 | Both units locked and the downstream unit released |
| relock_count | output | CNT_W | Number of downstream reset re-assertions after first full lock |

## Verification
A hold counter that is off by even one cycle shows up as an early or late fall of `up_rst`, right at the HOLD_CYCLES boundary. A delay chain that is shifted wrongly or reset to the wrong value shows up as a `dn_rst` release that comes earlier or later than STAGES cycles after the synchronised lock. It can also appear as a release while the upstream lock is absent. A wrong arm flag or wrong edge detection for the counter appears as a wrong `relock_count` at the first downstream re-assertion. The bench runs its own cycle model alongside the design and compares all four outputs on every clock, so any such divergence is seen within one cycle of happening.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } lock_pair_t;

    function automatic logic [1:0] sat3_inc(input logic [1:0] v);
        return (v == 2'd3) ? 2'd3 : v + 2'd1;
    endfunction

endpackage

// File: rtl/crs_lock_sync.sv
module crs_lock_sync
    import crs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lock_pair_t raw,
    output lock_pair_t synced
);
    localparam int NBITS = $bits(lock_pair_t);

    logic [NBITS-1:0] meta_q;
    logic [NBITS-1:0] sync_q;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= raw[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign synced = sync_q;

endmodule

// File: rtl/crs_hold_timer.sv
module crs_hold_timer #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_done,
    output logic hold_rst
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_END = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    initial begin
        AST_HOLD_MIN_LEN: assert (HOLD_CYCLES >= 3); // R3
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_done) begin
            cnt_q <= '0;
        end else if (cnt_q != HOLD_END) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_rst = (cnt_q != HOLD_END);

    AST_HOLD_ON_CFG_LOW: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |=> hold_rst); // R2

endmodule

// File: rtl/crs_delay_chain.sv
module crs_delay_chain #(
    parameter int STAGES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic dly_rst
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst || req) begin
            sr_q <= '1;
        end else begin
            sr_q <= {sr_q[STAGES-2:0], 1'b0};
        end
    end

    assign dly_rst = sr_q[STAGES-1];

    AST_CHAIN_REASSERT: assert property (@(posedge clk) disable iff (rst)
        req |=> dly_rst); // R5

    AST_CHAIN_QUIET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(dly_rst) |-> $past(!req)); // R6

endmodule

// File: rtl/cascade_rst_seq.sv
module cascade_rst_seq
    import crs_pkg::*;
#(
    parameter int HOLD_CYCLES = 1024,
    parameter int STAGES      = 16,
    parameter int CNT_W       = 8
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             cfg_done,
    input  logic             up_lock,
    input  logic             dn_lock,
    output logic             up_rst,
    output logic             dn_rst,
    output logic             all_locked,
    output logic [CNT_W-1:0] relock_count
);
    lock_pair_t raw_lk;
    lock_pair_t s_lk;
    logic       dn_req;
    logic       armed_q;
    logic       all_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0] up_run_q;

    assign raw_lk.up = up_lock;
    assign raw_lk.dn = dn_lock;

    crs_lock_sync u_sync (
        .clk    (clk_ref),
        .rst    (rst),
        .raw    (raw_lk),
        .synced (s_lk)
    );

    crs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk_ref),
        .rst      (rst),
        .cfg_done (cfg_done),
        .hold_rst (up_rst)
    );

    assign dn_req = up_rst | ~s_lk.up;

    crs_delay_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk_ref),
        .rst     (rst),
        .req     (dn_req),
        .dly_rst (dn_rst)
    );

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            all_q   <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            all_q   <= s_lk.up & s_lk.dn & ~dn_rst;
            armed_q <= armed_q | all_q;
            if (armed_q && dn_req && !dn_rst) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign all_locked   = all_q;
    assign relock_count = cnt_q;

    // run length of up_rst, saturating at 3, used only by the R3 check
    always_ff @(posedge clk_ref) begin
        if (rst) begin
            up_run_q <= 2'd3;
        end else if (up_rst) begin
            up_run_q <= sat3_inc(up_run_q);
        end else begin
            up_run_q <= 2'd0;
        end
    end

    AST_UP_PULSE_LEN: assert property (@(posedge clk_ref) disable iff (rst)
        $fell(up_rst) |-> up_run_q == 2'd3); // R3

    AST_ALL_NEEDS_RELEASE: assert property (@(posedge clk_ref) disable iff (rst)
        all_locked |-> $past(!dn_rst)); // R8

    AST_COUNT_STEP: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(relock_count) |-> relock_count == $past(relock_count) + 1'b1); // R9

    AST_COUNT_ON_RISE: assert property (@(posedge clk_ref) disable iff (rst)
        !$stable(relock_count) |-> $rose(dn_rst)); // R9

endmodule

// File: tb/cascade_rst_seq_test.sv
module cascade_rst_seq_test;
    localparam int HOLD   = 20;
    localparam int STG    = 16;
    localparam int CW     = 8;

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic cfg_done = 1'b0;
    logic up_lock = 1'b0;
    logic dn_lock = 1'b0;
    logic up_rst, dn_rst, all_locked;
    logic [CW-1:0] relock_count;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    cascade_rst_seq #(.HOLD_CYCLES(HOLD), .STAGES(STG), .CNT_W(CW)) uut (
        .clk_ref      (clk_ref),
        .rst          (rst),
        .cfg_done     (cfg_done),
        .up_lock      (up_lock),
        .dn_lock      (dn_lock),
        .up_rst       (up_rst),
        .dn_rst       (dn_rst),
        .all_locked   (all_locked),
        .relock_count (relock_count)
    );

    always #4 clk_ref = ~clk_ref;

    // behavioural reference model
    bit m_u1, m_u2, m_d1, m_d2;
    int m_hold;   // edges with cfg_done high since last low
    int m_quiet;  // consecutive quiet edges for downstream release
    bit m_all, m_armed;
    int m_cnt;

    function automatic bit exp_up_rst();  return m_hold < HOLD; endfunction
    function automatic bit exp_dn_rst();  return m_quiet < STG; endfunction

    always @(posedge clk_ref) begin
        bit req, old_dn;
        cycles++;
        if (rst) begin
            m_u1 = 0; m_u2 = 0; m_d1 = 0; m_d2 = 0;
            m_hold = 0; m_quiet = 0; m_all = 0; m_armed = 0; m_cnt = 0;
        end else begin
            old_dn = exp_dn_rst();
            req    = exp_up_rst() || !m_u2;
            if (m_armed && req && !old_dn) m_cnt = (m_cnt + 1) % (1 << CW);
            m_armed = m_armed || m_all;
            m_all   = m_u2 && m_d2 && !old_dn;
            if (req) m_quiet = 0;
            else if (m_quiet < STG) m_quiet++;
            m_u2 = m_u1; m_u1 = up_lock;
            m_d2 = m_d1; m_d1 = dn_lock;
            if (!cfg_done) m_hold = 0;
            else if (m_hold < HOLD) m_hold++;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp_v);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk_ref) begin
        if (!done && cycles > 0) begin
            chk(rst ? "R1 up_rst" : "R2/R3 up_rst", up_rst, exp_up_rst());
            chk("R5/R6/R7 dn_rst", dn_rst, exp_dn_rst());
            chk("R4/R8 all_locked", all_locked, m_all);
            chk("R9 relock_count", relock_count, m_cnt);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk_ref);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        wait_cyc(5);
        chk("R1 reset up_rst", up_rst, 1);
        chk("R1 reset dn_rst", dn_rst, 1);
        chk("R1 reset all_locked", all_locked, 0);
        chk("R1 reset relock_count", relock_count, 0);
        rst = 1'b0;
        // early lock before configuration completes: must not release downstream (R7, R6)
        up_lock = 1'b1;
        wait_cyc(12);
        chk("R7 early lock ignored", dn_rst, 1);
        chk("R2 hold while cfg low", up_rst, 1);
        up_lock = 1'b0;
        cfg_done = 1'b1;
        wait_cyc(HOLD - 1);
        chk("R2 still held one edge before end", up_rst, 1);
        wait_cyc(1);
        chk("R2 released after HOLD edges", up_rst, 0);
        // upstream locks; downstream release after sync + chain
        up_lock = 1'b1;
        wait_cyc(STG + 1);
        chk("R6 dn_rst held one cycle before release", dn_rst, 1);
        wait_cyc(1);
        chk("R6 dn_rst released", dn_rst, 0);
        dn_lock = 1'b1;
        wait_cyc(4);
        chk("R8 all locked", all_locked, 1);
        // short upstream lock loss
        up_lock = 1'b0;
        wait_cyc(3);
        chk("R5 dn_rst reasserted", dn_rst, 1);
        chk("R8 all_locked dropped", all_locked, 0);
        chk("R9 first relock counted", relock_count, 1);
        up_lock = 1'b1;
        wait_cyc(STG + 6);
        chk("R6 re-released", dn_rst, 0);
        // downstream-only loss: no count
        dn_lock = 1'b0;
        wait_cyc(4);
        chk("R8 dn loss clears status", all_locked, 0);
        chk("R9 no count on dn loss", relock_count, 1);
        dn_lock = 1'b1;
        wait_cyc(5);
        // one-cycle upstream glitch
        @(negedge clk_ref); up_lock = 1'b0;
        @(negedge clk_ref); up_lock = 1'b1;
        wait_cyc(6);
        chk("R9 glitch counted", relock_count, 2);
        wait_cyc(STG + 6);
        // configuration drop restarts hold
        cfg_done = 1'b0;
        wait_cyc(1);
        chk("R2 cfg low re-asserts up_rst", up_rst, 1);
        wait_cyc(2);
        chk("R5 dn follows up_rst", dn_rst, 1);
        chk("R9 cfg drop counted", relock_count, 3);
        cfg_done = 1'b1;
        wait_cyc(HOLD + STG + 6);
        chk("R6 full resequence", dn_rst, 0);
        chk("R8 relocked", all_locked, 1);
        // mid-run reset
        rst = 1'b1;
        wait_cyc(2);
        chk("R1 reset clears count", relock_count, 0);
        rst = 1'b0;
        wait_cyc(HOLD + STG + 6);
        finish_run();
    end

    initial begin
        wait (cycles > 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
    end

endmodule